// File: doc/BRIEF.md
# Peripheral Bus Requester with Slave-Paced Wait States

This block sits between a simple command source and one peripheral on an APB3 bus. A command carries an address, a write flag and write data, and is taken with a valid/ready handshake. The block turns each accepted command into one bus transfer made of a setup cycle and an access cycle. It keeps the access cycle going for as long as the peripheral reports that it is not yet ready.

The ready input from the peripheral is treated as a level and is looked at again on every access cycle. The block keeps no latency count. Each transfer therefore lasts exactly as long as its own peripheral response needs. A slow transfer leaves no trace on the one that follows it. When the transfer finishes, the read data and the peripheral's error flag are returned together with a one-cycle done pulse. A command that is already waiting when a transfer finishes is started at once, with no idle cycle between the two.

Top module: `pbreq_top`

## Requirements
- R1: One cycle after a command is accepted in the idle state, `bus_sel` is 1 and `bus_enable` is 0 (setup). In the following cycle both are 1 (access).
- R2: While the access phase sees `bus_ready` low, the access phase continues. During that time `bus_sel`, `bus_enable`, `bus_addr`, `bus_write` and `bus_wdata` keep their values.
- R3: The transfer completes on the first clock edge in access where `bus_ready` is sampled high. When `bus_ready` is already high in the first access cycle, `bus_sel` is high for exactly two cycles.
- R4: Read data is captured on the completion edge. It appears on `rsp_rdata` together with `rsp_done` in the cycle after that edge. `rsp_done` is a pulse that lasts one cycle.
- R5: `bus_err` is sampled on the completion edge and returned on `rsp_err` alongside `rsp_done`.
- R6: A transfer that follows a long-stalled transfer, and whose peripheral is ready at once, again takes exactly two bus cycles.
- R7: `cmd_ready` is 1 in the idle state and in the access cycle where `bus_ready` is 1. It is 0 in setup and in every stalled access cycle.
- R8: When `cmd_valid` is 1 in the completing access cycle, the next cycle is setup for the new command: `bus_sel` stays 1, `bus_enable` is 0, and the bus carries the new command fields.
- R9: When no command is offered in the completing cycle, the block returns to idle with `bus_sel` and `bus_enable` at 0.
- R10: While `rst_n` is 0, `bus_sel`, `bus_enable` and `rsp_done` are 0 and `cmd_ready` is 1, even when reset arrives in the middle of a stalled transfer.
- R11: Values on `bus_rdata` and `bus_err` during stalled access cycles have no effect. `rsp_rdata` keeps the value from the previous transfer until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_done | output | 1 | One-cycle pulse marking a finished transfer |
| rsp_rdata | output | DATA_W | Data captured at completion |
| rsp_err | output | 1 | Peripheral error captured at completion |
| bus_sel | output | 1 | Peripheral select |
| bus_enable | output | 1 | Access-phase marker |
| bus_addr | output | ADDR_W | Bus address |
| bus_write | output | 1 | Bus direction |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ready | input | 1 | Peripheral ready level |
| bus_rdata | input | DATA_W | Peripheral read data |
| bus_err | input | 1 | Peripheral error |

## Verification
After an accepting edge, setup is due one cycle later and access two cycles later. Completion happens on the edge where `bus_ready` is seen high, and the response appears one cycle after that edge. `cmd_ready` follows `bus_ready` in the same cycle, with no register in between. The bench drives every input on the falling edge and reads every output on the following falling edge. It counts the stall cycles that each vector requests, so each check lands in the exact cycle where the state is due. Back-to-back, stall-then-zero-wait and reset-while-stalled cases are run one by one after the vector table.

// File: rtl/pbreq_pkg.sv
package pbreq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;

  // Transfer ends on an access cycle that sees the ready level high.
  function automatic logic f_finish(input phase_t ph, input logic rdy);
    return (ph == PH_ACCESS) && rdy;
  endfunction

  // A new command may be taken when the bus is free or freeing this cycle.
  function automatic logic f_can_take(input phase_t ph, input logic rdy);
    return (ph == PH_IDLE) || f_finish(ph, rdy);
  endfunction

  function automatic phase_t f_next(input phase_t ph, input logic rdy,
                                    input logic vld);
    phase_t nx;
    case (ph)
      PH_IDLE:   nx = vld ? PH_SETUP : PH_IDLE;
      PH_SETUP:  nx = PH_ACCESS;
      PH_ACCESS: nx = rdy ? (vld ? PH_SETUP : PH_IDLE) : PH_ACCESS;
      default:   nx = PH_IDLE;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/pbreq_seq.sv
module pbreq_seq
  import pbreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic bus_ready,
  output logic take,
  output logic finish,
  output logic stall,
  output logic sel,
  output logic enable
);

  phase_t ph_q;
  phase_t ph_d;

  always_comb begin
    ph_d   = f_next(ph_q, bus_ready, cmd_valid);
    take   = f_can_take(ph_q, bus_ready);
    finish = f_finish(ph_q, bus_ready);
    stall  = (ph_q == PH_ACCESS) && !bus_ready;
    sel    = (ph_q != PH_IDLE);
    enable = (ph_q == PH_ACCESS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  AST_SETUP_LEADS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SETUP) |=> (ph_q == PH_ACCESS)); // R1

  AST_STALL_KEEPS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ph_q == PH_ACCESS)); // R2

  AST_CHAIN_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && cmd_valid) |=> (ph_q == PH_SETUP)); // R8

  AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !cmd_valid) |=> (ph_q == PH_IDLE)); // R9

endmodule

// File: rtl/pbreq_hold.sv
module pbreq_hold #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              stall,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write,
  output logic [DATA_W-1:0] out_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_write <= 1'b0;
      out_wdata <= '0;
    end else if (load) begin
      out_addr  <= in_addr;
      out_write <= in_write;
      out_wdata <= in_wdata;
    end
  end

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(out_addr) && $stable(out_write) && $stable(out_wdata))); // R2

endmodule

// File: rtl/pbreq_resp.sv
module pbreq_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              finish,
  input  logic [DATA_W-1:0] in_rdata,
  input  logic              in_err,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        rdata <= in_rdata;
        err   <= in_err;
      end
    end
  end

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(rdata)); // R11

endmodule

// File: rtl/pbreq_top.sv
module pbreq_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_sel,
  output logic              bus_enable,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);

  logic take_w;
  logic finish_w;
  logic stall_w;
  logic load_w;

  pbreq_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .bus_ready (bus_ready),
    .take      (take_w),
    .finish    (finish_w),
    .stall     (stall_w),
    .sel       (bus_sel),
    .enable    (bus_enable)
  );

  assign cmd_ready = take_w;
  assign load_w    = take_w && cmd_valid;

  pbreq_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .stall     (stall_w),
    .in_addr   (cmd_addr),
    .in_write  (cmd_write),
    .in_wdata  (cmd_wdata),
    .out_addr  (bus_addr),
    .out_write (bus_write),
    .out_wdata (bus_wdata)
  );

  pbreq_resp #(.DATA_W(DATA_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .finish   (finish_w),
    .in_rdata (bus_rdata),
    .in_err   (bus_err),
    .done     (rsp_done),
    .rdata    (rsp_rdata),
    .err      (rsp_err)
  );

  AST_ENABLE_UNDER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_enable |-> bus_sel); // R1

  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !(bus_enable && bus_ready)) |-> !cmd_ready); // R7

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(bus_sel && bus_enable && bus_ready)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R4

endmodule

// File: tb/pbreq_top_tb.sv
module pbreq_top_tb_top;

  localparam int AW = 12;
  localparam int DW = 32;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [3:0]    waits;
    logic [DW-1:0] rdata;
    logic          err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h010, 32'h0000_0000, 4'd0, 32'hA5A5_0001, 1'b0},
    '{1'b1, 12'h124, 32'hDEAD_BEEF, 4'd1, 32'h0000_1111, 1'b0},
    '{1'b0, 12'h3F8, 32'h0000_0000, 4'd3, 32'h1234_5678, 1'b1},
    '{1'b1, 12'h004, 32'h0F0F_0F0F, 4'd0, 32'h7777_0000, 1'b1},
    '{1'b0, 12'hFFC, 32'h0000_0000, 4'd7, 32'hCAFE_F00D, 1'b0},
    '{1'b1, 12'h800, 32'h8000_0001, 4'd2, 32'h0BAD_0BAD, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          bus_sel;
  logic          bus_enable;
  logic [AW-1:0] bus_addr;
  logic          bus_write;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_err = 1'b0;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;
  logic [DW-1:0] last_rd = '0;

  always #5 clk = ~clk;

  pbreq_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic offer(input vec_t v);
    cmd_valid = 1'b1;
    cmd_write = v.wr;
    cmd_addr  = v.addr;
    cmd_wdata = v.wdata;
  endtask

  // Runs one transfer from idle; called at a negedge with the bus idle.
  task automatic run_xfer(input vec_t v);
    offer(v);
    bus_ready = 1'b0;
    check("R7 cmd_ready in idle", {31'b0, cmd_ready}, 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 setup sel/en", {30'b0, bus_sel, bus_enable}, 32'd2);
    check("R7 cmd_ready in setup", {31'b0, cmd_ready}, 32'd0);
    check("R1 setup addr", {20'b0, bus_addr}, {20'b0, v.addr});
    check("R1 setup write/wdata", bus_wdata ^ {31'b0, bus_write},
          v.wdata ^ {31'b0, v.wr});
    for (int w = 0; w <= int'(v.waits); w++) begin
      @(negedge clk);
      check("R2 access sel/en", {30'b0, bus_sel, bus_enable}, 32'd3);
      check("R2 addr stable", {20'b0, bus_addr}, {20'b0, v.addr});
      check("R2 wdata stable", bus_wdata, v.wdata);
      if (w < int'(v.waits)) begin
        bus_ready = 1'b0;
        bus_rdata = ~v.rdata;
        bus_err   = ~v.err;
        #1;
        check("R7 cmd_ready low while stalled", {31'b0, cmd_ready}, 32'd0);
        check("R11 rdata held during stall", rsp_rdata, last_rd);
      end else begin
        bus_ready = 1'b1;
        bus_rdata = v.rdata;
        bus_err   = v.err;
        #1;
        check("R7 cmd_ready on completing cycle", {31'b0, cmd_ready}, 32'd1);
      end
    end
    @(negedge clk);
    bus_ready = 1'b0;
    bus_rdata = 32'h5555_AAAA;
    bus_err   = 1'b1;
    check("R4 done pulse", {31'b0, rsp_done}, 32'd1);
    check("R4 read data", rsp_rdata, v.rdata);
    check("R5 error flag", {31'b0, rsp_err}, {31'b0, v.err});
    check("R9 back to idle", {30'b0, bus_sel, bus_enable}, 32'd0);
    last_rd = v.rdata;
    @(negedge clk);
    check("R4 done lasts one cycle", {31'b0, rsp_done}, 32'd0);
    check("R11 rdata kept after done", rsp_rdata, last_rd);
    bus_err = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t a;
    vec_t b;
    int sel_cycles;
    @(negedge clk);
    check("R10 reset sel/en", {30'b0, bus_sel, bus_enable}, 32'd0);
    check("R10 reset done", {31'b0, rsp_done}, 32'd0);
    check("R10 reset cmd_ready", {31'b0, cmd_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk.
    for (int i = 0; i < NV; i++) run_xfer(VECS[i]);

    // R3: zero-wait transfer keeps bus_sel high for exactly two cycles.
    offer(VECS[3]);
    bus_ready = 1'b1;
    bus_rdata = 32'h2222_3333;
    sel_cycles = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (bus_sel) sel_cycles++;
      @(negedge clk);
    end
    check("R3 zero-wait sel cycles", sel_cycles, 32'd2);
    bus_ready = 1'b0;
    last_rd = 32'h2222_3333;
    @(negedge clk);

    // R8 / R6: long stall, next command chained, then zero-wait.
    a = VECS[4];
    b = VECS[1];
    offer(a);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);                       // first access cycle
    for (int w = 0; w < 5; w++) begin
      bus_ready = 1'b0;
      @(negedge clk);
    end
    offer(b);
    bus_ready = 1'b1;
    bus_rdata = a.rdata;
    bus_err   = 1'b1;
    #1;
    check("R7 cmd_ready while chaining", {31'b0, cmd_ready}, 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    bus_rdata = b.rdata;
    bus_err   = 1'b0;
    check("R8 chained setup sel/en", {30'b0, bus_sel, bus_enable}, 32'd2);
    check("R8 chained addr", {20'b0, bus_addr}, {20'b0, b.addr});
    check("R8 chained wdata", bus_wdata, b.wdata);
    check("R5 first done with error", {30'b0, rsp_done, rsp_err}, 32'd3);
    check("R4 first response data", rsp_rdata, a.rdata);
    @(negedge clk);
    check("R6 second access immediately", {30'b0, bus_sel, bus_enable}, 32'd3);
    @(negedge clk);
    bus_ready = 1'b0;
    check("R6 second done after two cycles", {31'b0, rsp_done}, 32'd1);
    check("R6 second response data", rsp_rdata, b.rdata);
    check("R9 idle after chain", {30'b0, bus_sel, bus_enable}, 32'd0);
    @(negedge clk);

    // R10: reset during a stalled access.
    offer(VECS[2]);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 still stalled", {30'b0, bus_sel, bus_enable}, 32'd3);
    rst_n = 1'b0;
    #1;
    check("R10 reset mid-stall sel/en", {30'b0, bus_sel, bus_enable}, 32'd0);
    check("R10 reset mid-stall cmd_ready", {31'b0, cmd_ready}, 32'd1);
    check("R10 reset mid-stall done", {31'b0, rsp_done}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset release", {30'b0, bus_sel, bus_enable}, 32'd0);

    finish_run();
  end

endmodule